// File: doc/BRIEF.md
# Byte-Port Sample FIFO with Threshold Interrupt

This block sits between a converter that produces 16-bit samples and a host that reads through an 8-bit port. Samples are pushed as whole words on one side. On the other side they leave as two byte reads: the low byte first, then the high byte. The store holds 4096 bytes, which is 2048 samples. The block drives a status byte and an interrupt built from sticky event bits.

The host port has two uses, chosen by a mode bit in the command byte. In data mode, reads on the port return sample bytes. In program mode, writes on the port load the thresholds in a fixed sequence. The near-full threshold is given as the number of bytes that are still free, not as a fill level. The near-full flag is set once the free space falls to that value or below it. A flush bit in the command byte empties the store and realigns the byte phase.

Events latch into the status byte: threshold reached, end of scan and data lost. They stay set until the host reads the status. The interrupt output is the OR of the pending events whose enables are set.

Top module: `sample_fifo_irq`

## Requirements
- R1: After reset the status byte reads 0x01 (empty only), the interrupt is low, the port is in program mode, the near-full threshold is 2048 free bytes, and both interrupt enables are off.
- R2: In data mode each sample is read as two port reads. The first read returns bits 7:0 and the second returns bits 15:8. The sample leaves the store on the second read. Samples come out in the order they were pushed.
- R3: The store holds 2048 samples. Status bit 2 (full) is set while it holds 2048. A sample pushed while the store is full is discarded, and the contents do not change.
- R4: Status bit 0 (empty) is set while the store holds no sample. A port read while the store is empty has no effect: the next read after a push still returns a low byte.
- R5: A command write selects data mode when bit 0 is 1 and program mode when bit 0 is 0. When bit 6 is 1, the write empties the store, and the next data read returns a low byte.
- R6: In program mode, port writes are taken in groups of four. Writes 1 and 2 (the near-empty threshold) have no effect on the flags. Write 3 sets bits 7:0 and write 4 sets the upper bits of the near-full threshold in free bytes. Port writes in data mode are ignored and do not advance the sequence.
- R7: Status bit 1 (near-full) is set when the free space, 4096 minus two times the stored sample count, is at or below the near-full threshold.
- R8: Status bit 3 (threshold event) latches one cycle after the near-full flag goes from 0 to 1.
- R9: A pulse on the end-of-scan input latches status bit 4. A discarded push latches status bit 5 (data lost).
- R10: Event bits 5:3 stay set until a status read. A status read clears the events that were latched before it. An event that arrives in the same cycle as the read stays set.
- R11: The interrupt is high when any enabled event is pending. Control bit 3 enables the threshold and data-lost events. Control bit 4 enables the end-of-scan event. The interrupt falls once those events are cleared.
- R12: Port reads in program mode neither consume a sample nor move the byte phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command byte strobe |
| cmd_data_i | input | 8 | Command byte: bit 0 selects data mode, bit 6 flushes |
| ctrl_wr_i | input | 1 | Control byte strobe |
| ctrl_data_i | input | 8 | Control byte: bit 3 enables the FIFO interrupt, bit 4 enables the end-of-scan interrupt |
| smp_valid_i | input | 1 | Converter sample strobe |
| smp_data_i | input | 16 | Converter sample |
| eos_i | input | 1 | End-of-scan pulse |
| port_wr_i | input | 1 | Host port write strobe |
| port_wdata_i | input | 8 | Host port write byte |
| port_rd_i | input | 1 | Host port read strobe |
| port_rdata_o | output | 8 | Host port read byte, valid in the cycle of the strobe |
| stat_rd_i | input | 1 | Status read strobe, clears latched events |
| stat_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench programs a threshold of 4088 free bytes, so the near-full flag must be clear at three samples and set at four. This separates a correct `<=` comparison from an off-by-one error and from counting free space in samples instead of bytes.

A low-byte read is placed before a flush, and reads are issued on an empty store and in program mode. These show whether the byte phase realigns or drifts.

A status read is made in the same cycle as an end-of-scan pulse, which separates "clear then set" from "clear everything". Filling to 2048 and pushing one more sample shows whether the extra sample is discarded and flagged or silently stored. Port writes made in data mode before the near-full check show whether they leak into the threshold.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int ST_EMPTY = 0;
  localparam int ST_NFULL = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_THR   = 3;
  localparam int ST_EOS   = 4;
  localparam int ST_LOST  = 5;
  localparam int CMD_DATA  = 0;
  localparam int CMD_FLUSH = 6;
  localparam int CTL_FIFO_IE = 3;
  localparam int CTL_EOS_IE  = 4;

  typedef struct packed {
    logic lost;
    logic eos;
    logic thr;
  } evt_t;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          drop_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign drop_o  = push_i & full_o & ~flush_i;
  assign head_o  = mem[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (cnt_q == $past(cnt_q)));
  p_flush_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/sfifo_thr_prog.sv
module sfifo_thr_prog #(
  parameter int TW = 13,
  parameter logic [TW-1:0] RST_THR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [7:0]    din_i,
  output logic [TW-1:0] thr_o
);
  logic [1:0]    idx_q;
  logic [TW-1:0] thr_q;
  logic          unused_hi;

  assign unused_hi = ^din_i[7:TW-8];
  assign thr_o = thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      thr_q <= RST_THR;
    end else if (flush_i) begin
      idx_q <= '0;
    end else if (wr_i) begin
      idx_q <= idx_q + 1'b1;
      // writes 0 and 1 carry the near-empty level, which no flag uses
      if (idx_q == 2'd2) thr_q[7:0] <= din_i;
      if (idx_q == 2'd3) thr_q[TW-1:8] <= din_i[TW-9:0];
    end
  end

  p_thr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (thr_q == $past(thr_q)));
endmodule

// File: rtl/sfifo_events.sv
module sfifo_events
  import sfifo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  evt_t set_i,
  input  logic clr_i,
  input  logic fifo_ie_i,
  input  logic eos_ie_i,
  output evt_t ev_o,
  output logic irq_o
);
  evt_t ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= '0;
    else         ev_q <= (clr_i ? evt_t'('0) : ev_q) | set_i;
  end

  assign ev_o  = ev_q;
  assign irq_o = (fifo_ie_i & (ev_q.thr | ev_q.lost)) | (eos_ie_i & ev_q.eos);

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((3'(ev_q) & 3'($past(ev_q))) == 3'($past(ev_q))));
  p_same_cycle_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i.eos) |=> ev_q.eos);
  p_irq_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> ($past(clr_i) || ($past(fifo_ie_i) != fifo_ie_i)
                      || ($past(eos_ie_i) != eos_ie_i)));
endmodule

// File: rtl/sample_fifo_irq.sv
module sample_fifo_irq
  import sfifo_pkg::*;
#(
  parameter int FIFO_BYTES = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_wr_i,
  input  logic [7:0]  cmd_data_i,
  input  logic        ctrl_wr_i,
  input  logic [7:0]  ctrl_data_i,
  input  logic        smp_valid_i,
  input  logic [15:0] smp_data_i,
  input  logic        eos_i,
  input  logic        port_wr_i,
  input  logic [7:0]  port_wdata_i,
  input  logic        port_rd_i,
  output logic [7:0]  port_rdata_o,
  input  logic        stat_rd_i,
  output logic [7:0]  stat_o,
  output logic        irq_o
);
  localparam int DEPTH = FIFO_BYTES / 2;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int TW    = $clog2(FIFO_BYTES) + 1;
  localparam logic [TW-1:0] CAP_B = TW'(FIFO_BYTES);

  logic          data_mode_q, phase_q, fifo_ie_q, eos_ie_q, nf_q;
  logic          flush, rd_ok, pop, full, empty, drop, nf;
  logic [15:0]   head;
  logic [CW-1:0] count;
  logic [TW-1:0] thr, free_b;
  evt_t          ev_set, ev;
  logic          unused_bits;

  assign unused_bits = ^{cmd_data_i[7], cmd_data_i[5:1], ctrl_data_i[7:5], ctrl_data_i[2:0]};

  assign flush = cmd_wr_i & cmd_data_i[CMD_FLUSH];
  assign rd_ok = port_rd_i & data_mode_q & ~empty;
  assign pop   = rd_ok & phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_mode_q <= 1'b0;
      phase_q     <= 1'b0;
      fifo_ie_q   <= 1'b0;
      eos_ie_q    <= 1'b0;
      nf_q        <= 1'b0;
    end else begin
      if (cmd_wr_i) data_mode_q <= cmd_data_i[CMD_DATA];
      if (ctrl_wr_i) begin
        fifo_ie_q <= ctrl_data_i[CTL_FIFO_IE];
        eos_ie_q  <= ctrl_data_i[CTL_EOS_IE];
      end
      if (flush)      phase_q <= 1'b0;
      else if (rd_ok) phase_q <= ~phase_q;
      nf_q <= nf;
    end
  end

  sfifo_store #(.DW(16), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .flush_i (flush),
    .push_i  (smp_valid_i),
    .din_i   (smp_data_i),
    .pop_i   (pop),
    .head_o  (head),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty),
    .drop_o  (drop)
  );

  sfifo_thr_prog #(.TW(TW), .RST_THR(TW'(FIFO_BYTES / 2))) u_thr (
    .clk_i, .rst_ni,
    .flush_i (flush),
    .wr_i    (port_wr_i & ~data_mode_q),
    .din_i   (port_wdata_i),
    .thr_o   (thr)
  );

  // free space counted in bytes, a half-read sample still occupies both
  assign free_b = CAP_B - {count, 1'b0};
  assign nf     = (free_b <= thr);

  assign ev_set.thr  = nf & ~nf_q;
  assign ev_set.eos  = eos_i;
  assign ev_set.lost = drop;

  sfifo_events u_evt (
    .clk_i, .rst_ni,
    .set_i     (ev_set),
    .clr_i     (stat_rd_i),
    .fifo_ie_i (fifo_ie_q),
    .eos_ie_i  (eos_ie_q),
    .ev_o      (ev),
    .irq_o     (irq_o)
  );

  assign port_rdata_o = phase_q ? head[15:8] : head[7:0];
  assign stat_o = {2'b00, ev.lost, ev.eos, ev.thr, full, nf, empty};

  p_phase_realign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !phase_q);
  p_prog_no_pop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_mode_q && !smp_valid_i && !flush) |=> (count == $past(count)));
  p_empty_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && !flush) |=> (phase_q == $past(phase_q)));
  p_lost_latch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && smp_valid_i && !flush) |=> stat_o[ST_LOST]);
endmodule

// File: tb/sample_fifo_irq_tb.sv
`timescale 1ns/1ps
module sample_fifo_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 0, ctrl_wr = 0, smp_valid = 0, eos = 0;
  logic        port_wr = 0, port_rd = 0, stat_rd = 0;
  logic [7:0]  cmd_d = 0, ctrl_d = 0, wdata = 0;
  logic [15:0] smp_d = 0;
  logic [7:0]  rdata, stat;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  logic [15:0] sb_q[$];

  always #4 clk = ~clk;

  sample_fifo_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_wr_i(cmd_wr), .cmd_data_i(cmd_d),
    .ctrl_wr_i(ctrl_wr), .ctrl_data_i(ctrl_d),
    .smp_valid_i(smp_valid), .smp_data_i(smp_d),
    .eos_i(eos),
    .port_wr_i(port_wr), .port_wdata_i(wdata),
    .port_rd_i(port_rd), .port_rdata_o(rdata),
    .stat_rd_i(stat_rd), .stat_o(stat),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] v);
    cmd_wr = 1; cmd_d = v; @(negedge clk); cmd_wr = 0;
  endtask

  task automatic ctrl(input logic [7:0] v);
    ctrl_wr = 1; ctrl_d = v; @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic pwrite(input logic [7:0] v);
    port_wr = 1; wdata = v; @(negedge clk); port_wr = 0;
  endtask

  // driver: expected samples go to the scoreboard when they fit
  task automatic push(input logic [15:0] v);
    smp_valid = 1; smp_d = v;
    if (sb_q.size() < 2048) sb_q.push_back(v);
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic rd_byte(output logic [7:0] b);
    port_rd = 1; #1 b = rdata; @(negedge clk); port_rd = 0;
  endtask

  task automatic stat_read(output logic [7:0] s);
    stat_rd = 1; #1 s = stat; @(negedge clk); stat_rd = 0;
  endtask

  // monitor: two byte reads against the scoreboard head
  task automatic rd_sample(input string req);
    logic [7:0] lo, hi;
    logic [15:0] exp;
    rd_byte(lo);
    rd_byte(hi);
    exp = (sb_q.size() > 0) ? sb_q.pop_front() : 16'hxxxx;
    chk(req, {hi, lo}, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] b, s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    // R1 reset state
    chk("R1 status", stat, 8'h01);
    chk("R1 irq", irq, 1'b0);

    ctrl(8'h08);
    // R6 program: first two writes are near-empty, then 4088 free bytes
    pwrite(8'hAA); pwrite(8'hBB); pwrite(8'hF8); pwrite(8'h0F);
    cmd(8'h01);
    // R6 data-mode writes must not reach the threshold
    pwrite(8'h00); pwrite(8'h00); pwrite(8'h00); pwrite(8'h00);

    push(16'h1101); push(16'h2202); push(16'h3303); idle();
    chk("R7 three samples below threshold", stat, 8'h00);
    chk("R11 irq idle", irq, 1'b0);
    push(16'h4404); idle();
    chk("R7 R8 near-full and threshold event", stat, 8'h0A);
    chk("R11 irq raised", irq, 1'b1);
    stat_read(s);
    chk("R10 read shows event", s, 8'h0A);
    chk("R10 event cleared", stat, 8'h02);
    chk("R11 irq cleared", irq, 1'b0);

    // R12 program-mode read ignored
    cmd(8'h00); rd_byte(b); cmd(8'h01);
    rd_sample("R2 R12 sample 0");
    rd_sample("R2 sample 1");
    rd_sample("R2 sample 2");
    rd_sample("R2 sample 3");
    chk("R4 empty after drain", stat, 8'h01);

    // R4 read while empty has no effect
    rd_byte(b);
    push(16'h1234);
    rd_sample("R4 low byte after empty read");

    // R5 flush in mid-sample
    push(16'hBEEF); push(16'hCAFE);
    rd_byte(b);
    chk("R2 low byte first", b, 8'hEF);
    cmd(8'h41);
    sb_q.delete();
    chk("R5 flush empties", stat, 8'h01);
    push(16'h5A3C);
    rd_sample("R5 low byte after flush");

    // R9 R10 end of scan
    ctrl(8'h10);
    eos = 1; @(negedge clk); eos = 0;
    chk("R9 eos latched", stat, 8'h11);
    chk("R11 eos irq", irq, 1'b1);
    eos = 1; stat_rd = 1; #1 s = stat; @(negedge clk); eos = 0; stat_rd = 0;
    chk("R10 same-cycle event kept", stat, 8'h11);
    stat_read(s);
    chk("R10 eos cleared", stat, 8'h01);
    chk("R11 irq low", irq, 1'b0);

    // R3 capacity and overflow
    ctrl(8'h08);
    for (int i = 0; i < 2048; i++) push(16'(i * 7 + 3));
    idle();
    chk("R3 full flag", stat, 8'h0E);
    push(16'hFFFF);
    chk("R3 R9 drop flagged", stat, 8'h2E);
    chk("R11 lost irq", irq, 1'b1);
    for (int i = 0; i < 2048; i++) rd_sample("R3 contents");
    chk("R3 extra sample discarded", stat, 8'h29);

    finish_run();
  end
endmodule